// File: doc/BRIEF.md
# PWM Timer Channel

A single up-counting timer channel with a power-of-four prescaler, a counter whose clear source is selectable, four compare values and one output pin. The control inputs are already decoded fields, so the block sits behind whatever register file owns them. It is used either as a plain interval timer or, with the mode field set to PWM, as a pulse-width generator: the counter then wraps after compare B, and the pin starts each period at a programmed level and switches at compare A.

The pin behaviour is set by a 3-bit output code. The top bit is the level the pin takes when the code is loaded and at the start of each PWM period. The low two bits give the action at a compare-A match. A code with no action holds the pin at a fixed level, which is how 0 % and 100 % outputs are produced without running the counter.

Top module: `pwm_timer_channel`

## Requirements
- R1: While rst_n is low, count is 0 and pin is 0.
- R2: Prescaler code div_sel = p divides the clock by 4^p. With edge_sel = 1 (falling), the counter advances once every 4^p clocks of run, first after 4^p clocks. With p = 0 it advances on every clock of run, whatever edge_sel holds.
- R3: edge_sel = 0 (rising) makes the first advance come after half of 4^p clocks and later ones every 4^p clocks. edge_sel = 2 or 3 (both) advances every half of 4^p clocks.
- R4: While run is low, the counter and the prescaler phase both hold their values.
- R5: clr_sel picks the clear source: 1 compare A, 2 compare B, 5 compare C, 6 compare D; every other code means no clear. On an advance where count equals the selected compare value, count becomes 0 instead of count+1.
- R6: With mode_sel = 2 (PWM), the counter clears on compare B whatever clr_sel holds. On the advance where count equals cmp_b, the pin returns to the starting level, so the period is cmp_b+1 advances.
- R7: out_ctl[2] is the starting level. out_ctl[1:0] is the action on an advance where count equals cmp_a: 1 drive 0, 2 drive 1, 3 invert.
- R8: out_ctl[1:0] = 0 holds the pin at out_ctl[2] from the next clock, whatever the counter does.
- R9: A change of out_ctl loads the pin with the new out_ctl[2] on the next clock, even while the counter is stopped.
- R10: In PWM mode the compare-B return wins over a compare-A action on the same advance. When cmp_a is above cmp_b, the pin never leaves the starting level.
- R11: A new cmp_a is used from the next comparison on. It neither restarts the period nor moves the counter.
- R12: In any mode other than 2, the compare-A action is applied on every compare-A match, and the pin is never returned to the starting level by compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Channel start bit |
| div_sel | input | 2 | Prescaler code p, divide by 4^p |
| edge_sel | input | 2 | Counting edge: 0 rising, 1 falling, 2/3 both |
| clr_sel | input | 3 | Counter clear source code |
| mode_sel | input | 2 | 2 selects PWM, others normal |
| out_ctl | input | 3 | Starting level and compare-A action |
| cmp_a | input | W | Compare value A |
| cmp_b | input | W | Compare value B |
| cmp_c | input | W | Compare value C |
| cmp_d | input | W | Compare value D |
| pin | output | 1 | Output pin level |
| count | output | W | Counter value |

## Verification
Most internal faults reach the count port within one prescaled period. A wrong prescaler phase shifts the first advance by a fixed number of clocks, and a wrong clear source changes the wrap point on the first pass through the compare value. Faults in the pin logic show up as a wrong high-time summed over two complete PWM periods, or in the level one clock after an output-code change. Stop-and-resume and a mid-period change of compare A are checked at the exact clock where the counter or the pin must move.

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [1:0]   div_sel,
  input  logic [1:0]   edge_sel,
  input  logic [2:0]   clr_sel,
  input  logic [1:0]   mode_sel,
  input  logic [2:0]   out_ctl,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [W-1:0] cmp_c,
  input  logic [W-1:0] cmp_d,
  output logic         pin,
  output logic [W-1:0] count
);
  localparam int MAXP  = 3;
  localparam int PRE_W = 2 * MAXP;

  logic [PRE_W-1:0] pre_cnt, pre_mask, pre_low;
  logic             rise_pt, fall_pt, tick;
  logic             pwm_on, clr_en, clr_hit, hit_a, hit_b;
  logic [W-1:0]     clr_val;
  logic [2:0]       ioc_q;
  logic             fixed_lvl, ioc_new, pin_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pre_cnt <= '0;
    else if (run) pre_cnt <= pre_cnt + 1'b1;

  always_comb begin
    pre_mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < 2 * int'(div_sel)) pre_mask[i] = 1'b1;
  end

  assign pre_low = pre_cnt & pre_mask;
  assign rise_pt = pre_low == (pre_mask >> 1);
  assign fall_pt = pre_low == pre_mask;

  always_comb begin
    if (div_sel == 2'd0) tick = run;
    else case (edge_sel)
      2'd0:    tick = run && rise_pt;
      2'd1:    tick = run && fall_pt;
      default: tick = run && (rise_pt || fall_pt);
    endcase
  end

  assign pwm_on = mode_sel == 2'd2;

  always_comb begin
    clr_en  = 1'b1;
    clr_val = cmp_b;
    if (!pwm_on)
      case (clr_sel)
        3'd1:    clr_val = cmp_a;
        3'd2:    clr_val = cmp_b;
        3'd5:    clr_val = cmp_c;
        3'd6:    clr_val = cmp_d;
        default: clr_en  = 1'b0;
      endcase
  end

  assign clr_hit = clr_en && (count == clr_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    count <= '0;
    else if (tick) count <= clr_hit ? '0 : count + 1'b1;

  assign hit_a     = tick && (count == cmp_a);
  assign hit_b     = tick && pwm_on && (count == cmp_b);
  assign fixed_lvl = out_ctl[1:0] == 2'd0;
  assign ioc_new   = out_ctl != ioc_q;

  always_comb begin
    pin_nx = pin;
    if (fixed_lvl || ioc_new) pin_nx = out_ctl[2];
    else if (hit_b)           pin_nx = out_ctl[2];
    else if (hit_a)
      case (out_ctl[1:0])
        2'd1:    pin_nx = 1'b0;
        2'd2:    pin_nx = 1'b1;
        default: pin_nx = ~pin;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin   <= 1'b0;
      ioc_q <= 3'd0;
    end else begin
      pin   <= pin_nx;
      ioc_q <= out_ctl;
    end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(count) && $stable(pre_cnt)));

  // R6
  pwm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && tick && count == cmp_b) |=> count == '0);

  // R10
  pwm_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && tick && count == cmp_b) |=> pin == $past(out_ctl[2]));

  // R8
  fixed_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ctl[1:0] == 2'd0) |=> pin == $past(out_ctl[2]));

  // R9
  code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ctl != ioc_q) |=> pin == $past(out_ctl[2]));
endmodule

// File: tb/test_pwm_timer_channel.sv
module test_pwm_timer_channel;
  localparam int W = 16;
  localparam time TCLK = 10ns;

  typedef struct packed {
    logic [1:0]  dv;
    logic [2:0]  oc;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] ones;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 3'd5, 16'd3, 16'd9, 16'd8},
    '{2'd0, 3'd2, 16'd3, 16'd9, 16'd12},
    '{2'd1, 3'd5, 16'd1, 16'd4, 16'd16},
    '{2'd0, 3'd7, 16'd0, 16'd5, 16'd2},
    '{2'd0, 3'd6, 16'd2, 16'd5, 16'd12},
    '{2'd0, 3'd1, 16'd2, 16'd5, 16'd0},
    '{2'd0, 3'd5, 16'd5, 16'd5, 16'd12},
    '{2'd0, 3'd5, 16'd8, 16'd5, 16'd12},
    '{2'd2, 3'd5, 16'd0, 16'd1, 16'd32},
    '{2'd0, 3'd3, 16'd1, 16'd3, 16'd4},
    '{2'd0, 3'd4, 16'd1, 16'd3, 16'd8},
    '{2'd0, 3'd0, 16'd1, 16'd3, 16'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [1:0] div_sel = '0, edge_sel = '0, mode_sel = '0;
  logic [2:0] clr_sel = '0, out_ctl = '0;
  logic [W-1:0] cmp_a = '0, cmp_b = '0, cmp_c = '0, cmp_d = '0;
  logic pin;
  logic [W-1:0] count;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  pwm_timer_channel #(.W(W)) i_pwm_timer_channel (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .edge_sel(edge_sel),
    .clr_sel(clr_sel), .mode_sel(mode_sel), .out_ctl(out_ctl),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cmp_d(cmp_d),
    .pin(pin), .count(count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] dv, input logic [1:0] ed, input logic [2:0] cs,
                       input logic [1:0] md, input logic [2:0] oc,
                       input int a, input int b, input int c, input int d);
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0;
    div_sel = dv; edge_sel = ed; clr_sel = cs; mode_sel = md; out_ctl = oc;
    cmp_a = W'(a); cmp_b = W'(b); cmp_c = W'(c); cmp_d = W'(d);
    adv(2);
    rst_n = 1'b1;
    adv(2);
    run = 1'b1;
  endtask

  task automatic chk_cnt(input string req, input int exp);
    check(int'(count) == exp, req, int'(count), exp);
  endtask

  task automatic chk_pin(input string req, input int exp);
    check(int'(pin) == exp, req, int'(pin), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    adv(3);
    // R1 reset state
    chk_cnt("R1 count", 0);
    chk_pin("R1 pin", 0);

    // R6 R7 R8 R10 table: PWM mode, falling edge, clr_sel left at 0
    for (int v = 0; v < NV; v++) begin
      int n, ones;
      n = 2 * (int'(TBL[v].b) + 1) * (1 << (2 * int'(TBL[v].dv)));
      ones = 0;
      setup(TBL[v].dv, 2'd1, 3'd0, 2'd2, TBL[v].oc, int'(TBL[v].a), int'(TBL[v].b), 0, 0);
      for (int i = 0; i < n; i++) begin
        if (i > 0) adv(1);
        ones += int'(pin);
      end
      check(ones == int'(TBL[v].ones), $sformatf("R6 R7 R8 R10 vector %0d high time", v),
            ones, int'(TBL[v].ones));
      adv(1);
      check(count == '0, $sformatf("R6 vector %0d wrap", v), int'(count), 0);
    end

    // R2 falling edge, divide by 4 and by 64
    setup(2'd1, 2'd1, 3'd0, 2'd0, 3'd1, 100, 100, 100, 100);
    adv(3); chk_cnt("R2 p1 before", 0);
    adv(1); chk_cnt("R2 p1 first", 1);
    setup(2'd3, 2'd1, 3'd0, 2'd0, 3'd1, 100, 100, 100, 100);
    adv(63); chk_cnt("R2 p3 before", 0);
    adv(1);  chk_cnt("R2 p3 first", 1);

    // R3 rising and both edges
    setup(2'd1, 2'd0, 3'd0, 2'd0, 3'd1, 100, 100, 100, 100);
    adv(1); chk_cnt("R3 rising before", 0);
    adv(1); chk_cnt("R3 rising first", 1);
    adv(4); chk_cnt("R3 rising second", 2);
    setup(2'd1, 2'd2, 3'd0, 2'd0, 3'd1, 100, 100, 100, 100);
    adv(4); chk_cnt("R3 both", 2);
    setup(2'd1, 2'd3, 3'd0, 2'd0, 3'd1, 100, 100, 100, 100);
    adv(4); chk_cnt("R3 code3 both", 2);

    // R4 stop holds counter and prescaler phase
    setup(2'd0, 2'd1, 3'd0, 2'd0, 3'd1, 100, 100, 100, 100);
    adv(7); chk_cnt("R4 running", 7);
    run = 1'b0;
    adv(5); chk_cnt("R4 held", 7);
    run = 1'b1;
    adv(1); chk_cnt("R4 resumed", 8);
    setup(2'd1, 2'd1, 3'd0, 2'd0, 3'd1, 100, 100, 100, 100);
    adv(2); run = 1'b0;
    adv(10); run = 1'b1;
    adv(1); chk_cnt("R4 phase held", 0);
    adv(1); chk_cnt("R4 phase resumed", 1);

    // R5 clear sources
    setup(2'd0, 2'd1, 3'd1, 2'd0, 3'd1, 4, 100, 100, 100);
    adv(4); chk_cnt("R5 clear A reach", 4);
    adv(1); chk_cnt("R5 clear A", 0);
    setup(2'd0, 2'd1, 3'd2, 2'd0, 3'd1, 100, 3, 100, 100);
    adv(4); chk_cnt("R5 clear B", 0);
    setup(2'd0, 2'd1, 3'd5, 2'd0, 3'd1, 100, 100, 2, 100);
    adv(3); chk_cnt("R5 clear C", 0);
    setup(2'd0, 2'd1, 3'd6, 2'd0, 3'd1, 100, 100, 100, 6);
    adv(6); chk_cnt("R5 clear D reach", 6);
    adv(1); chk_cnt("R5 clear D", 0);
    setup(2'd0, 2'd1, 3'd3, 2'd0, 3'd1, 2, 5, 3, 4);
    adv(12); chk_cnt("R5 code3 no clear", 12);
    setup(2'd0, 2'd1, 3'd0, 2'd0, 3'd1, 2, 5, 3, 4);
    adv(20); chk_cnt("R5 code0 no clear", 20);

    // R12 normal mode actions
    setup(2'd0, 2'd1, 3'd1, 2'd0, 3'd7, 4, 100, 100, 100);
    chk_pin("R12 toggle start", 1);
    adv(5); chk_pin("R12 toggle first", 0);
    adv(5); chk_pin("R12 toggle second", 1);
    setup(2'd0, 2'd1, 3'd1, 2'd0, 3'd5, 2, 1, 100, 100);
    adv(3); chk_pin("R12 clear action", 0);
    adv(3); chk_pin("R12 no restore", 0);

    // R11 compare A change mid-period
    setup(2'd0, 2'd1, 3'd0, 2'd2, 3'd5, 2, 9, 0, 0);
    adv(1); chk_pin("R11 before change", 1);
    cmp_a = W'(6);
    adv(3); chk_cnt("R11 no restart", 4);
    adv(2); chk_pin("R11 old match ignored", 1);
    adv(1); chk_pin("R11 new match", 0);

    // R9 output-code change
    setup(2'd0, 2'd1, 3'd0, 2'd2, 3'd5, 5, 9, 0, 0);
    adv(2); chk_pin("R9 running high", 1);
    out_ctl = 3'd1;
    adv(1); chk_pin("R9 load low", 0);
    run = 1'b0; out_ctl = 3'd5;
    adv(1); chk_pin("R9 load high stopped", 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule